// File: doc/BRIEF.md
# Runtime-Programmable Window Address Translator

This block converts 32-bit addresses arriving from a memory-mapped slave into 64-bit PCI Express addresses. Four bits of each incoming address select one of sixteen windows in a register-based table. The selected window supplies the upper 44 bits of the outgoing address and a 2-bit address-space code. The lowest 20 bits of the request pass through unchanged. Any request bits above the selector field are dropped.

The table is empty after reset. Software fills it at run time, once host address allocation is known. It does this through a separate control port that can write and read every window. Translated requests leave through a single registered stage with a valid/ready handshake. A lookup therefore never competes with a table update for a port: the two paths act on the same clock edge, and the lookup sees the table as it was before that edge.

Top module: `win_xlate`

## Requirements
- R1: After reset, outValid and cfgRvalid are low. Every control word reads as zero, and a translation yields zero in output bits [63:20] with space code 0.
- R2: Request address bits [23:20] select the window. Bits [31:24] have no effect on the result.
- R3: Output bits [63:20] come from the selected window. Bits [31:20] are taken from the low control word's bits [31:20], and bits [63:32] from the high control word's bits [31:0].
- R4: Output bits [19:0] equal request bits [19:0].
- R5: outSpace equals bits [1:0] of the selected window's low control word.
- R6: Control word address cfgAddr = {window[3:0], half}. Half 0 selects the low word and half 1 the high word. Low-word bits [19:2] read back as zero whatever was written there.
- R7: A read presented on cfgRead returns its data on cfgRdata with cfgRvalid high in the next cycle only. Without a read, cfgRvalid is low.
- R8: When a control write and an accepted lookup target the same window in the same cycle, the lookup uses the old contents. Later lookups see the new value.
- R9: reqReady is high whenever outValid is low or outReady is high. An accepted request appears on the outputs with outValid high one cycle later, and accepted requests may follow back to back.
- R10: While outValid is high and outReady is low, outValid, outAddr and outSpace hold and reqReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request address valid |
| reqReady | output | 1 | Request accepted this cycle if valid |
| reqAddr | input | 32 | Incoming slave address |
| outValid | output | 1 | Translated address valid |
| outReady | input | 1 | Consumer takes the translated address |
| outAddr | output | 64 | Translated PCI Express address |
| outSpace | output | 2 | Address-space code of the selected window |
| cfgWrite | input | 1 | Control word write strobe |
| cfgRead | input | 1 | Control word read strobe |
| cfgAddr | input | 5 | Control word index {window, half} |
| cfgWdata | input | 32 | Control write data |
| cfgRvalid | output | 1 | Read data valid |
| cfgRdata | output | 32 | Read data |

## Verification
A translated address is due one cycle after the clock edge that accepts it. A control read is due one cycle after the edge where cfgRead is sampled. A table write is visible to lookups accepted on any later edge. The bench drives just after a rising edge and samples at the falling edge, so each result is compared exactly one edge after its cause. A scoreboard queue holds predictions made from a bench-side model of the table, and during stalls the monitor compares only when the consumer takes the output.

// File: rtl/win_xlate_pkg.sv
package win_xlate_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic wrLo;   // write low word of a window
    logic wrHi;   // write high word of a window
    logic load;   // capture a lookup into the output stage
    logic rdGo;   // capture control read data
  } xlateStrobe_t;
endpackage

// File: rtl/win_xlate_ctrl.sv
module win_xlate_ctrl
  import win_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         outReady,
  input  logic         cfgWrite,
  input  logic         cfgRead,
  input  logic         cfgHalf,
  output logic         reqReady,
  output logic         outValid,
  output logic         cfgRvalid,
  output xlateStrobe_t strobe
);
  logic outValidQ;
  logic rvalidQ;
  logic advance;

  assign advance = !outValidQ || outReady;

  always_comb begin
    strobe.wrLo = cfgWrite && !cfgHalf;
    strobe.wrHi = cfgWrite && cfgHalf;
    strobe.load = reqValid && advance;
    strobe.rdGo = cfgRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      rvalidQ   <= 1'b0;
    end else begin
      if (advance) outValidQ <= reqValid;
      rvalidQ <= cfgRead;
    end
  end

  assign reqReady  = advance;
  assign outValid  = outValidQ;
  assign cfgRvalid = rvalidQ;
endmodule

// File: rtl/win_xlate_dpath.sv
module win_xlate_dpath
  import win_xlate_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int OUT_AW    = 64,
  parameter int PASS_BITS = 20,
  parameter int IDX_BITS  = 4,
  parameter int SPACE_W   = 2,
  parameter int CTRL_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlateStrobe_t        strobe,
  input  logic [IN_AW-1:0]    reqAddr,
  input  logic [IDX_BITS:0]   cfgAddr,
  input  logic [CTRL_W-1:0]   cfgWdata,
  output logic [OUT_AW-1:0]   outAddr,
  output logic [SPACE_W-1:0]  outSpace,
  output logic [CTRL_W-1:0]   cfgRdata
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int HI_W    = OUT_AW - PASS_BITS;   // bits from the table
  localparam int LO_F    = CTRL_W - PASS_BITS;   // table bits held in low word
  localparam int UP_F    = HI_W - LO_F;          // table bits held in high word
  localparam int GAP_W   = PASS_BITS - SPACE_W;  // low word bits reading zero

  logic [HI_W-1:0]    tblHi [ENTRIES];
  logic [SPACE_W-1:0] tblSp [ENTRIES];

  logic [IDX_BITS-1:0] lkIdx;
  logic [IDX_BITS-1:0] cfgIdx;
  logic                cfgHalf;
  logic                unusedReqHigh;

  assign lkIdx         = reqAddr[PASS_BITS +: IDX_BITS];
  assign cfgIdx        = cfgAddr[IDX_BITS:1];
  assign cfgHalf       = cfgAddr[0];
  assign unusedReqHigh = ^reqAddr[IN_AW-1:PASS_BITS+IDX_BITS];

  // Window table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tblHi[e] <= '0;
        tblSp[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (cfgIdx == IDX_BITS'(e)) begin
          if (strobe.wrLo) begin
            tblHi[e][LO_F-1:0] <= cfgWdata[CTRL_W-1:PASS_BITS];
            tblSp[e]           <= cfgWdata[SPACE_W-1:0];
          end
          if (strobe.wrHi) tblHi[e][HI_W-1:LO_F] <= cfgWdata[UP_F-1:0];
        end
      end
    end
  end

  // Output stage: table upper bits joined to untouched low bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr  <= '0;
      outSpace <= '0;
    end else if (strobe.load) begin
      outAddr  <= {tblHi[lkIdx], reqAddr[PASS_BITS-1:0]};
      outSpace <= tblSp[lkIdx];
    end
  end

  // Control read-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRdata <= '0;
    end else if (strobe.rdGo) begin
      if (cfgHalf)
        cfgRdata <= CTRL_W'(tblHi[cfgIdx][HI_W-1:LO_F]);
      else
        cfgRdata <= {tblHi[cfgIdx][LO_F-1:0], {GAP_W{1'b0}}, tblSp[cfgIdx]};
    end
  end
endmodule

// File: rtl/win_xlate.sv
module win_xlate
  import win_xlate_pkg::*;
#(
  parameter int IN_AW     = 32,
  parameter int OUT_AW    = 64,
  parameter int PASS_BITS = 20,
  parameter int IDX_BITS  = 4,
  parameter int SPACE_W   = 2,
  parameter int CTRL_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [IN_AW-1:0]   reqAddr,
  output logic               outValid,
  input  logic               outReady,
  output logic [OUT_AW-1:0]  outAddr,
  output logic [SPACE_W-1:0] outSpace,
  input  logic               cfgWrite,
  input  logic               cfgRead,
  input  logic [IDX_BITS:0]  cfgAddr,
  input  logic [CTRL_W-1:0]  cfgWdata,
  output logic               cfgRvalid,
  output logic [CTRL_W-1:0]  cfgRdata
);
  xlateStrobe_t strobe;

  win_xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .outReady  (outReady),
    .cfgWrite  (cfgWrite),
    .cfgRead   (cfgRead),
    .cfgHalf   (cfgAddr[0]),
    .reqReady  (reqReady),
    .outValid  (outValid),
    .cfgRvalid (cfgRvalid),
    .strobe    (strobe)
  );

  win_xlate_dpath #(
    .IN_AW     (IN_AW),
    .OUT_AW    (OUT_AW),
    .PASS_BITS (PASS_BITS),
    .IDX_BITS  (IDX_BITS),
    .SPACE_W   (SPACE_W),
    .CTRL_W    (CTRL_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .outAddr  (outAddr),
    .outSpace (outSpace),
    .cfgRdata (cfgRdata)
  );
endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk #(
  parameter int IN_AW     = 32,
  parameter int OUT_AW    = 64,
  parameter int PASS_BITS = 20,
  parameter int IDX_BITS  = 4,
  parameter int SPACE_W   = 2,
  parameter int CTRL_W    = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [IN_AW-1:0]   reqAddr,
  input logic               outValid,
  input logic               outReady,
  input logic [OUT_AW-1:0]  outAddr,
  input logic [SPACE_W-1:0] outSpace,
  input logic               cfgWrite,
  input logic               cfgRead,
  input logic [IDX_BITS:0]  cfgAddr,
  input logic [CTRL_W-1:0]  cfgWdata,
  input logic               cfgRvalid,
  input logic [CTRL_W-1:0]  cfgRdata
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outSpace));

  p_pass_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> outValid && (outAddr[PASS_BITS-1:0] == $past(reqAddr[PASS_BITS-1:0])));

  p_rd_due_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgRead |=> cfgRvalid);

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRead |=> !cfgRvalid);

  p_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> reqReady);

  p_lo_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgRvalid && ($past(cfgAddr[0]) == 1'b0) |-> cfgRdata[PASS_BITS-1:SPACE_W] == '0);
endmodule

bind win_xlate win_xlate_chk #(
  .IN_AW(IN_AW), .OUT_AW(OUT_AW), .PASS_BITS(PASS_BITS),
  .IDX_BITS(IDX_BITS), .SPACE_W(SPACE_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/win_xlate_bench.sv
module win_xlate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outAddr;
  logic [1:0]  outSpace;
  logic        cfgWrite = 1'b0;
  logic        cfgRead = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        cfgRvalid;
  logic [31:0] cfgRdata;

  int checks = 0;
  int fails = 0;

  logic [43:0] mHi [16];
  logic [1:0]  mSp [16];
  logic [65:0] expQ [$];

  always #5 clk = ~clk;

  win_xlate u_win_xlate (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: predict from the model, then offer until accepted
  task automatic sendReq(input logic [31:0] a);
    logic [3:0] idx;
    idx = a[23:20];
    expQ.push_back({mSp[idx], mHi[idx], a[19:0]});
    reqAddr  = a;
    reqValid = 1'b1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic cfgWr(input logic [4:0] a, input logic [31:0] d);
    cfgAddr  = a;
    cfgWdata = d;
    cfgWrite = 1'b1;
    @(posedge clk);
    #1 cfgWrite = 1'b0;
    if (a[0]) mHi[a[4:1]][43:12] = d;
    else begin
      mHi[a[4:1]][11:0] = d[31:20];
      mSp[a[4:1]]       = d[1:0];
    end
  endtask

  // R6/R7: read one word and compare at the next falling edge
  task automatic cfgRdChk(input logic [4:0] a, input string req);
    logic [31:0] exp;
    exp = a[0] ? mHi[a[4:1]][43:12] : {mHi[a[4:1]][11:0], 18'h0, mSp[a[4:1]]};
    cfgAddr = a;
    cfgRead = 1'b1;
    @(posedge clk);
    #1 cfgRead = 1'b0;
    @(negedge clk);
    chk(cfgRvalid === 1'b1, "R7 rvalid", 64'(cfgRvalid), 64'd1);
    chk(cfgRdata === exp, req, 64'(cfgRdata), 64'(exp));
  endtask

  // Monitor: compare whenever the consumer takes a result (R3, R4, R5)
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9 unexpected output", outAddr, 64'h0);
      end else begin
        logic [65:0] e;
        e = expQ.pop_front();
        chk(outAddr === e[63:0], "R3/R4 address", outAddr, e[63:0]);
        chk(outSpace === e[65:64], "R5 space", 64'(outSpace), 64'(e[65:64]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) begin
      mHi[e] = '0;
      mSp[e] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outValid === 1'b0, "R1 outValid", 64'(outValid), 64'd0);
    chk(cfgRvalid === 1'b0, "R1 cfgRvalid", 64'(cfgRvalid), 64'd0);
    chk(reqReady === 1'b1, "R9 ready when idle", 64'(reqReady), 64'd1);
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(cfgRvalid === 1'b0, "R7 no read no rvalid", 64'(cfgRvalid), 64'd0);

    // R1: table zero after reset
    for (int w = 0; w < 32; w++) begin
      @(posedge clk);
      #1 cfgRdChk(5'(w), "R1 zero readback");
    end
    @(negedge clk);
    chk(cfgRvalid === 1'b0, "R7 rvalid single cycle", 64'(cfgRvalid), 64'd0);
    @(posedge clk);
    #1 sendReq(32'hFFF1_2345);   // R1, R4: zero high bits, low pass

    // R6: program windows, with junk in the low-word gap
    for (int e = 0; e < 16; e++) begin
      @(posedge clk);
      #1 cfgWr({4'(e), 1'b0}, {12'hA50 ^ 12'(e * 37), 18'h2AAAA, 2'(e)});
      cfgWr({4'(e), 1'b1}, 32'hC0DE_0000 | 32'(e * 4099));
    end
    for (int e = 0; e < 16; e += 5) begin
      cfgRdChk({4'(e), 1'b0}, "R6 low word, gap zero");
      cfgRdChk({4'(e), 1'b1}, "R6 high word");
    end

    // R2-R5, R9: every window, upper bits varied, back to back
    @(posedge clk);
    #1;
    for (int e = 0; e < 16; e++)
      sendReq({8'(e * 29 + 3), 4'(e), 20'(e * 40503)});
    sendReq(32'h0070_0ABC);
    sendReq(32'hFF70_0ABC);      // R2: same result despite top bits

    // R10: stall holds output and blocks the input
    @(negedge clk);
    @(posedge clk);
    #1 outReady = 1'b0;
    sendReq(32'h0030_1111);
    fork
      sendReq(32'h00B0_2222);
    join_none
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(outValid === 1'b1, "R10 valid held", 64'(outValid), 64'd1);
      chk(outAddr === {mHi[3], 20'h01111}, "R10 addr held", outAddr, {mHi[3], 20'h01111});
      chk(reqReady === 1'b0, "R10 ready low", 64'(reqReady), 64'd0);
    end
    @(posedge clk);
    #1 outReady = 1'b1;
    wait (expQ.size() == 0);
    @(negedge clk);

    // R8: write and lookup to window 5 in the same cycle
    @(posedge clk);
    #1;
    expQ.push_back({mSp[5], mHi[5], 20'h0BEEF});
    reqAddr  = 32'h0050_BEEF;
    reqValid = 1'b1;
    cfgAddr  = {4'd5, 1'b1};
    cfgWdata = 32'h1234_5678;
    cfgWrite = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    cfgWrite = 1'b0;
    mHi[5][43:12] = 32'h1234_5678;
    sendReq(32'h0050_BEEF);      // R8: new value afterwards

    wait (expQ.size() == 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule